// File: doc/BRIEF.md
# Tree 1:16 Deserializer with Selectable Bit Order

This block turns a serial bit stream, sampled once per cycle of a full-rate clock, into parallel words one sixteenth as fast. The data passes through a binary tree of 1:2 splitting stages. Stage k of the tree is paced by the k-th output of a chain of divide-by-2 stages. The whole block runs on the full-rate clock and uses clock enables derived from the divider chain, so it stays in a single clock domain. The last divider stage is brought out as the word clock that accompanies the parallel output.

A static select input picks which end of the output word carries the earliest bit of each 16-bit group. This lets the block feed a downstream consumer that expects either bit order without any rewiring. Grouping is fixed by reset: the first bit sampled after reset is released is bit 0 of group 0. Word framing and alignment are handled outside this block.

Top module: `tree_deser`

## Requirements
- R1: Each run of 16 consecutive input bits, counted from the first rising edge after reset release (edge 0 samples bit 0 of group 0), appears together as one output word. The word updates exactly once per 16 input bits.
- R2: With order_sel = 0, word_q[i] carries the i-th received bit of its group, so bit 0 holds the earliest bit.
- R3: With order_sel = 1, word_q[15-i] carries the i-th received bit of its group, so bit 15 holds the earliest bit.
- R4: Group g (bits sampled at edges 16g to 16g+15) becomes visible on word_q right after edge 16g+18. Until then, after reset, word_q stays at zero.
- R5: After an update, word_q holds its value for 16 full clock cycles, up to and including edge 16g+34. Tree stages change their outputs only on their load phase.
- R6: word_clk is the full-rate clock divided by 16. After edge t it equals 1 exactly when (t+1) mod 16 is in 8..15.
- R7: An active-low asynchronous reset clears word_q and word_clk to 0 at once. After release, grouping restarts from bit 0.
- R8: Changing order_sel while a word is held bit-reverses word_q straight away, without waiting for a clock edge and without disturbing the captured data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdin | input | 1 | Serial data, one bit per rising edge |
| order_sel | input | 1 | Bit order: 0 puts the earliest bit on bit 0, 1 puts it on bit 15 |
| word_q | output | 16 | Parallel output word |
| word_clk | output | 1 | Word clock, clk divided by 16 |

## Verification
The assertions check several properties on every cycle. They confirm that the divider wraps cleanly, that no tree stage moves outside its load phase, that the assembled word changes only on the final load phase, that reset leaves the outputs cleared, and that flipping the order select reverses a held word. Only the bench scenarios can show that the bits land in the right word positions for each order, that the first word arrives at the stated edge, that it holds for the stated window, and that grouping restarts from bit 0 after a reset in mid-stream. The bench shows this using walking-one, fixed and pseudo-random groups.

// File: rtl/tree_deser_pkg.sv
package tree_deser_pkg;
   // Phase (mod 2^k) on which a level-k splitter latches its first-half element.
   function automatic int hold_phase(input int k);
      return ((1 << (k - 1)) + k - 2) % (1 << k);
   endfunction

   // Phase (mod 2^k) on which a level-k splitter presents both halves together.
   function automatic int load_phase(input int k);
      return ((1 << k) + k - 2) % (1 << k);
   endfunction
endpackage

// File: rtl/tree_deser_divchain.sv
module tree_deser_divchain #(
   parameter int STAGES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [STAGES-1:0] phase
);
   logic [STAGES-1:0] carry;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         assign carry[i] = 1'b1;
      end else begin : g_next
         assign carry[i] = carry[i-1] & phase[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        phase[i] <= 1'b0;
         else if (carry[i]) phase[i] <= ~phase[i];
      end
   end

   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == '1) |=> (phase == '0));

   // R6
   top_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(phase[STAGES-1]) |-> ($past(phase[STAGES-2:0]) == '1));
endmodule

// File: rtl/tree_deser_split.sv
module tree_deser_split (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_en,
   input  logic       load_en,
   input  logic       din,
   output logic [1:0] dout
);
   logic first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= 1'b0;
         dout    <= 2'b00;
      end else begin
         if (hold_en) first_q <= din;
         if (load_en) dout    <= {din, first_q};
      end
   end

   // R5
   node_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(dout));

   // R1
   en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_en && load_en));
endmodule

// File: rtl/tree_deser_order.sv
module tree_deser_order #(
   parameter int W = 16
) (
   input  logic         sel,
   input  logic [W-1:0] lanes,
   output logic [W-1:0] word
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign word[i] = sel ? lanes[W-1-i] : lanes[i];
   end
endmodule

// File: rtl/tree_deser.sv
module tree_deser #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sdin,
   input  logic         order_sel,
   output logic [W-1:0] word_q,
   output logic         word_clk
);
   localparam int L      = $clog2(W);
   localparam int BUS_W  = 2 * W - 2;
   localparam int LOAD_L = tree_deser_pkg::load_phase(L);

   if (W < 4 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("tree_deser: W must be a power of two and at least 4");
   end

   logic [L-1:0]     phase;
   logic [BUS_W-1:0] tree_bus;
   logic [W-1:0]     lanes;

   tree_deser_divchain #(.STAGES(L)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   // Level k occupies tree_bus[2^(k+1)-3 : 2^k-2]; element index = bit position mod 2^k.
   for (genvar k = 1; k <= L; k++) begin : g_lvl
      localparam int HP   = tree_deser_pkg::hold_phase(k);
      localparam int LP   = tree_deser_pkg::load_phase(k);
      localparam int OFF  = (1 << k) - 2;
      localparam int PREV = (1 << (k - 1)) - 2;
      localparam int HALF = 1 << (k - 1);

      logic hold_en;
      logic load_en;
      assign hold_en = (phase[k-1:0] == HP[k-1:0]);
      assign load_en = (phase[k-1:0] == LP[k-1:0]);

      for (genvar j = 0; j < HALF; j++) begin : g_node
         logic node_in;
         if (k == 1) begin : g_src_ser
            assign node_in = sdin;
         end else begin : g_src_tree
            assign node_in = tree_bus[PREV+j];
         end

         tree_deser_split u_split (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_en (hold_en),
            .load_en (load_en),
            .din     (node_in),
            .dout    ({tree_bus[OFF+j+HALF], tree_bus[OFF+j]})
         );
      end
   end

   assign lanes    = tree_bus[BUS_W-1 -: W];
   assign word_clk = phase[L-1];

   tree_deser_order #(.W(W)) u_order (
      .sel   (order_sel),
      .lanes (lanes),
      .word  (word_q)
   );

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   // R1 R5
   word_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(lanes) |-> ($past(phase) == LOAD_L[L-1:0]));

   // R7
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((word_q == '0) && !word_clk));

   // R8
   order_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($changed(order_sel) && $stable(lanes)) |-> (word_q == flip($past(word_q))));
endmodule

// File: tb/tree_deser_bench.sv
module tree_deser_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sdin = 1'b0;
   logic         order_sel = 1'b0;
   logic [W-1:0] word_q;
   logic         word_clk;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   tree_deser #(.W(W)) u_tree_deser (
      .clk       (clk),
      .rst_n     (rst_n),
      .sdin      (sdin),
      .order_sel (order_sel),
      .word_q    (word_q),
      .word_clk  (word_clk)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Group value with the earliest bit in position 15.
   function automatic logic [15:0] grp(input int kind, input int g);
      logic [31:0] x;
      case (kind)
         0:       return 16'hC35A + 16'(g) * 16'h0F1E;
         1:       return 16'h8000 >> (g % 16);
         default: begin
            x = 32'(g + 1) * 32'h9E3779B1;
            return x[31:16] ^ x[15:0];
         end
      endcase
   endfunction

   function automatic logic bit_at(input int kind, input int t);
      logic [15:0] v;
      v = grp(kind, t / 16);
      return v[15 - (t % 16)];
   endfunction

   function automatic logic [15:0] rev16(input logic [15:0] v);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = v[15-i];
      return r;
   endfunction

   function automatic logic [15:0] expect_word(input logic sel, input int kind, input int g);
      return sel ? grp(kind, g) : rev16(grp(kind, g));
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 word under reset", word_q, '0);
      check("R7 word_clk under reset", {15'b0, word_clk}, '0);
   endtask

   task automatic run_stream(input logic sel, input int kind, input int ngroups,
                             input int swap_g, input int abort_t);
      do_reset();
      order_sel = sel;
      rst_n     = 1'b1;
      sdin      = bit_at(kind, 0);
      for (int t = 1; t < 16 * ngroups + 35; t++) begin
         @(negedge clk);
         if (t == 18)
            check("R4 no word before latency", word_q, '0);
         if (t >= 19 && (t - 19) % 16 == 0 && (t - 19) / 16 < ngroups)
            check(order_sel ? "R1/R3 word order" : "R1/R2 word order",
                  word_q, expect_word(order_sel, kind, (t - 19) / 16));
         if (t >= 34 && (t - 34) % 16 == 0 && (t - 34) / 16 < ngroups)
            check("R5 word held", word_q, expect_word(order_sel, kind, (t - 34) / 16));
         if (t < 32 && (t % 16 == 7 || t % 16 == 8))
            check("R6 word_clk", {15'b0, word_clk}, {15'b0, (t % 16) >= 8});
         if (swap_g >= 0 && t == 16 * swap_g + 20) begin
            order_sel = ~order_sel;
            #1;
            check("R8 order swap", word_q, expect_word(order_sel, kind, swap_g));
         end
         if (abort_t > 0 && t == abort_t) begin
            rst_n = 1'b0;
            #1;
            check("R7 async clear word", word_q, '0);
            check("R7 async clear word_clk", {15'b0, word_clk}, '0);
            break;
         end
         sdin = bit_at(kind, t);
      end
   endtask

   task automatic sc_lsb_first();   run_stream(1'b0, 0, 4, -1, 0); endtask
   task automatic sc_msb_first();   run_stream(1'b1, 0, 4, -1, 0); endtask
   task automatic sc_walking_one(); run_stream(1'b1, 1, 4, -1, 0); run_stream(1'b0, 1, 3, -1, 0); endtask
   task automatic sc_random();      run_stream(1'b0, 2, 6, -1, 0); endtask
   task automatic sc_swap();        run_stream(1'b0, 2, 4, 1, 0); endtask
   task automatic sc_mid_reset();   run_stream(1'b1, 2, 3, -1, 45); run_stream(1'b1, 2, 2, -1, 0); endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      sc_lsb_first();
      sc_msb_first();
      sc_walking_one();
      sc_random();
      sc_swap();
      sc_mid_reset();
      summary();
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end
endmodule